// File: doc/BRIEF.md
# Preset-Reload Programmable Frequency Divider

This block divides a fast input clock by a ratio that is set at run time from a 4-bit switch word. It has two parts. A toggle stage halves the input clock and gives a square wave at half the input rate. A 4-bit synchronous binary up-counter drives its own parallel load from the inverse of its terminal carry. Each time the count reaches all ones, the next rising edge reloads the switch preset. The division ratio is therefore 16 minus the preset, from 1 (preset 15) to 16 (preset 0). That range covers every ratio from 1 to 10.

The block is meant for the reference or feedback path of a frequency synthesizer. The carry output marks the terminal-count cycle. A registered copy of it gives a clean one-clock divided pulse. Two count enables behave like those of a classic cascadable counter. Counting needs both enables high. The carry-gating enable also forces the carry low, so a low level on it stops the reload as well. All state, including the clear, is synchronous to the input clock.

Top module: `preset_divider`

## Requirements
- R1: When `rst_n` is low at a rising edge, the count becomes 0 and `half_clk` and `div_pulse` become 0, so `carry` is 0 while reset is held.
- R2: After reset is released, `half_clk` inverts on every rising edge of `clk`. It is 1 after the first edge with `rst_n` high.
- R3: With `cnt_en` and `carry_en` both high, the count rises by one per edge. After reset release, `carry` first goes high after the 15th edge.
- R4: `carry` is high exactly when the count is 15 (all ones) and `carry_en` is high. The edge that ends such a cycle loads `preset`, so with both enables high `carry` repeats every 16 minus `preset` cycles, for every preset from 0 to 15.
- R5: While `carry_en` is low, `carry` is 0 and the count holds, and no reload takes place even at count 15.
- R6: While `cnt_en` is low and `carry_en` is high, the count holds. The exception is count 15: there the reload of the preset still happens on the next edge.
- R7: `preset` is sampled only on a reload edge. A change in the middle of a cycle leaves the current cycle's length unchanged and sets the length of the following one.
- R8: `div_pulse` is high in the cycle right after each cycle in which `carry` is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low clear |
| cnt_en | input | 1 | Count enable (affects counting only) |
| carry_en | input | 1 | Count enable that also gates the carry |
| preset | input | 4 | Switch preset loaded on each reload |
| div_pulse | output | 1 | Registered one-clock divided pulse |
| carry | output | 1 | Terminal-count carry, combinational |
| half_clk | output | 1 | Input clock divided by two |

## Verification
A corrupted count can only surface through `carry`. If the count is wrong, the terminal cycle comes early or late, and the first interval measured after the fault is off by the size of the error. It is visible within one division period of at most 16 cycles, and `div_pulse` repeats the error one cycle later. A wrong reload value or a missed reload shows up in the next interval as a ratio other than 16 minus the preset. A toggle stage that sticks shows up within two cycles as a `half_clk` that fails to alternate.

// File: rtl/div_pkg.sv
// Package div_pkg
// Shared types for the preset-reload divider: the action the counter
// takes on each edge. No assumptions beyond a single clock domain.
package div_pkg;

    typedef enum logic [1:0] {
        CNT_CLEAR = 2'd0,
        CNT_LOAD  = 2'd1,
        CNT_STEP  = 2'd2,
        CNT_HOLD  = 2'd3
    } cnt_action_t;

endpackage

// File: rtl/half_rate_toggle.sv
// Module half_rate_toggle
// A single flip-flop fed from its own inverse, giving a square wave at
// half the clock rate. Assumes a synchronous active-low reset to 0.
module half_rate_toggle (
    input  logic clk,
    input  logic rst_n,
    output logic half_q
);

    // Invert once per rising edge; clear to 0 in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else begin
            half_q <= ~half_q;
        end
    end

endmodule

// File: rtl/preset_counter.sv
// Module preset_counter
// Synchronous binary up-counter with a synchronous parallel load, two
// count enables and a terminal carry gated by en_t. The load input is
// active low. The parent is expected to tie it to the inverted carry,
// which closes the modulus loop. Load takes priority over the enables.
module preset_counter
    import div_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_p,
    input  logic             en_t,
    input  logic             load_n,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             tc_carry
);

    logic [CNT_W:0]   ones_below;
    logic [CNT_W-1:0] flip_mask;
    logic [CNT_W-1:0] count_nx;
    cnt_action_t      action;

    assign ones_below[0] = 1'b1;

    // Ripple chain: bit i flips when every lower bit is 1 and counting is on.
    for (genvar gi = 0; gi < CNT_W; gi++) begin : g_chain
        assign ones_below[gi+1] = ones_below[gi] & count[gi];
        assign flip_mask[gi]    = ones_below[gi] & en_p & en_t;
    end

    assign tc_carry = en_t & ones_below[CNT_W];

    // Pick the edge action: clear, then load, then step, else hold.
    always_comb begin
        if (!rst_n) begin
            action = CNT_CLEAR;
        end else if (!load_n) begin
            action = CNT_LOAD;
        end else if (en_p && en_t) begin
            action = CNT_STEP;
        end else begin
            action = CNT_HOLD;
        end
    end

    // Form the next count from the chosen action.
    always_comb begin
        unique case (action)
            CNT_CLEAR: count_nx = '0;
            CNT_LOAD:  count_nx = load_val;
            CNT_STEP:  count_nx = count ^ flip_mask;
            default:   count_nx = count;
        endcase
    end

    // Register the count.
    always_ff @(posedge clk) begin
        count <= count_nx;
    end

endmodule

// File: rtl/pulse_register.sv
// Module pulse_register
// One-flop retiming of a combinational pulse into a clean output.
// Assumes synchronous active-low reset to 0.
module pulse_register (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    // Capture the pulse one cycle late; clear in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/preset_divider.sv
// Module preset_divider
// Programmable divider: a divide-by-two toggle stage beside a
// preset-reload counter whose inverted terminal carry drives its own load.
// The ratio is 2**CNT_W minus the preset. Assumes one clock domain, with
// the preset already synchronous to clk (switch inputs are slow).
module preset_divider #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             carry_en,
    input  logic [CNT_W-1:0] preset,
    output logic             div_pulse,
    output logic             carry,
    output logic             half_clk
);

    logic [CNT_W-1:0] cnt_q;
    logic             tc_w;
    logic             reload_n;

    // Feedback: terminal carry, inverted, is the active-low load.
    assign reload_n = ~tc_w;
    assign carry    = tc_w;

    half_rate_toggle u_half (
        .clk    (clk),
        .rst_n  (rst_n),
        .half_q (half_clk)
    );

    preset_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_p     (cnt_en),
        .en_t     (carry_en),
        .load_n   (reload_n),
        .load_val (preset),
        .count    (cnt_q),
        .tc_carry (tc_w)
    );

    pulse_register u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (tc_w),
        .q     (div_pulse)
    );

endmodule

// File: rtl/preset_divider_chk.sv
// Module preset_divider_chk
// Property checker for preset_divider, attached by bind. It relates the
// internal count to the port behaviour across edges.
module preset_divider_chk #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             carry_en,
    input  logic [CNT_W-1:0] preset,
    input  logic             div_pulse,
    input  logic             carry,
    input  logic             half_clk,
    input  logic [CNT_W-1:0] cnt_q
);

    // The cycle after a carry cycle holds the preset sampled then.
    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> (cnt_q == $past(preset)));

    // With both enables high and no carry, the count steps by one.
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!carry && cnt_en && carry_en) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // Without carry and with either enable low, the count holds.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!carry && !(cnt_en && carry_en)) |=> $stable(cnt_q));

    // The gating enable low keeps the carry low.
    assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_en |-> !carry);

    // The half-rate output alternates every edge.
    assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (half_clk != $past(half_clk)));

    // The divided pulse follows the carry by one cycle.
    assert_pulse_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> div_pulse);
    assert_pulse_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !carry |=> !div_pulse);

endmodule

bind preset_divider preset_divider_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .carry_en  (carry_en),
    .preset    (preset),
    .div_pulse (div_pulse),
    .carry     (carry),
    .half_clk  (half_clk),
    .cnt_q     (cnt_q)
);

// File: tb/tb_preset_divider.sv
module tb_preset_divider;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cnt_en;
    logic       carry_en;
    logic [3:0] preset;
    logic       div_pulse;
    logic       carry;
    logic       half_clk;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    preset_divider dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .carry_en  (carry_en),
        .preset    (preset),
        .div_pulse (div_pulse),
        .carry     (carry),
        .half_clk  (half_clk)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One rising edge, then settle; sampling and driving happen here.
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wait_carry();
        int guard = 0;
        while (!carry && guard < 100) begin
            step();
            guard++;
        end
    endtask

    task automatic edges_to_carry(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!carry && n < 100);
    endtask

    initial begin
        int n;
        rst_n    = 1'b0;
        cnt_en   = 1'b1;
        carry_en = 1'b1;
        preset   = 4'd0;
        step(); step(); step();

        // R1: reset state
        check(carry == 1'b0, "R1 carry", carry, 0);
        check(div_pulse == 1'b0, "R1 div_pulse", div_pulse, 0);
        check(half_clk == 1'b0, "R1 half_clk", half_clk, 0);

        // R2 and R3: release reset, count edges to first carry
        rst_n = 1'b1;
        n = 0;
        do begin
            step();
            n++;
            check(half_clk == n[0], "R2 half_clk alternates", half_clk, n[0]);
        end while (!carry && n < 100);
        check(n == 15, "R3 first carry after reset", n, 15);

        // R4 and R8: every preset, both enables high
        for (int p = 0; p < 16; p++) begin
            preset = 4'(p);
            wait_carry();
            edges_to_carry(n);
            check(n == 16 - p, "R4 period", n, 16 - p);
            check(div_pulse == (p == 15), "R8 pulse at carry cycle", div_pulse, int'(p == 15));
            step();
            check(div_pulse == 1'b1, "R8 pulse after carry", div_pulse, 1);
        end

        // R6: count enable low mid-count holds the count
        preset = 4'd6;
        wait_carry();
        step(); step(); step();
        cnt_en = 1'b0;
        for (int i = 0; i < 20; i++) begin
            step();
            check(carry == 1'b0, "R6 hold mid-count", carry, 0);
        end
        cnt_en = 1'b1;
        edges_to_carry(n);
        check(n == 7, "R6 resume after hold", n, 7);

        // R6: count enable low at terminal count still reloads
        preset = 4'd10;
        wait_carry();
        cnt_en = 1'b0;
        step();
        check(carry == 1'b0, "R6 reload with count enable low", carry, 0);
        for (int i = 0; i < 5; i++) step();
        check(carry == 1'b0, "R6 held at preset", carry, 0);
        cnt_en = 1'b1;
        edges_to_carry(n);
        check(n == 5, "R6 count from loaded preset", n, 5);

        // R5: gating enable low at terminal count
        preset = 4'd6;
        wait_carry();
        carry_en = 1'b0;
        #1;
        check(carry == 1'b0, "R5 carry forced low", carry, 0);
        for (int i = 0; i < 5; i++) begin
            step();
            check(carry == 1'b0, "R5 carry stays low", carry, 0);
        end
        carry_en = 1'b1;
        #1;
        check(carry == 1'b1, "R5 count held at terminal", carry, 1);
        edges_to_carry(n);
        check(n == 10, "R5 reload after gate restored", n, 10);

        // R7: preset change mid-cycle
        preset = 4'd6;
        wait_carry();
        step(); step();
        preset = 4'd12;
        edges_to_carry(n);
        check(n == 8, "R7 current cycle unchanged", n, 8);
        edges_to_carry(n);
        check(n == 4, "R7 next cycle uses new preset", n, 4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule